// File: doc/BRIEF.md
# Priority Round-Robin Slave Arbiter

This block decides which of several bus masters owns one shared AHB-Lite slave. For each master it takes a request line, a priority level, the transfer type, the burst type and the master-lock flag. It also takes the HREADY of the shared slave bus. It drives a one-hot grant vector, the encoded index of the owner and an owner-valid flag. The grant comes from a register, so a decision made at one clock edge is visible from the next cycle onward.

The highest priority level wins. Among masters that share the winning level, a rotating pointer chooses the next one in turn. Once a master owns the slave it stays parked there, so repeat accesses by the same master cost no arbitration. Ownership moves only at a safe point: the owner is idle, or its burst has finished. It never moves while the owner holds its lock flag, and never on a cycle where HREADY is low. Address decoding, data multiplexing and wait-state insertion on the master side belong to the surrounding fabric.

Top module: `prio_rr_slave_arbiter`

## Requirements
- R1: The priority of master i is the field `prio_i[i*PRIO_W +: PRIO_W]`, where PRIO_W = clog2(NUM_MST). A larger value is a higher priority, so 0 is the lowest and NUM_MST-1 the highest. At a handover the winner is a requesting master with the highest requested level.
- R2: Among requesters that share the winning level, the search starts at the rotating pointer and moves upward, wrapping from NUM_MST-1 to 0. After each decision the pointer moves to the master just past the winner.
- R3: With no request the owner stays parked and the grant does not change. The grant only ever moves to a master that requested in the cycle before.
- R4: After the asynchronous active-low reset, the grant is all zero, owner_valid is 0 and the pointer is at master 0. So the first tie among equal priorities goes to master 0.
- R5: Ownership changes only at a rising edge where `hready_i` is 1. The new grant shows on `grant_o`, `owner_idx_o` and `owner_valid_o` in the cycle after that edge.
- R6: The owner counts as idle when its request is low or its HTRANS is IDLE (2'b00). An idle owner may be replaced at once.
- R7: A burst starts when the owner has a NONSEQ (2'b10) accepted at an edge with HREADY high. For fixed-length bursts (HBURST 3'b010/3'b011 = 4 beats, 3'b100/3'b101 = 8 beats, 3'b110/3'b111 = 16 beats), beats are counted only at edges with HREADY high. While beats remain, a SEQ (2'b11) or BUSY (2'b01) from the owner blocks any handover.
- R8: In an undefined-length INCR burst (HBURST 3'b001), SEQ and BUSY keep the burst open. Any other transfer type ends it and allows a handover at that edge.
- R9: While the owner drives its lock flag high, the grant stays on the owner whatever the priority of the others.
- R10: A higher-priority request that arrives while lower-priority masters are already waiting is served before them at the next safe point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_MST | Per-master request for this slave |
| prio_i | input | NUM_MST*PRIO_W | Per-master priority level, packed |
| htrans_i | input | NUM_MST*2 | Per-master transfer type, packed |
| hburst_i | input | NUM_MST*3 | Per-master burst type, packed |
| hmastlock_i | input | NUM_MST | Per-master lock flag |
| hready_i | input | 1 | HREADY of the shared slave bus |
| grant_o | output | NUM_MST | One-hot grant, zero when no owner |
| owner_idx_o | output | IDX_W | Index of the current owner |
| owner_valid_o | output | 1 | An owner exists |

## Verification
The assertions rely on the owner following legal AHB-Lite sequences. A burst opens with NONSEQ, a fixed-length burst never issues more SEQ beats than its type allows, and inputs settle well away from the clock edge. The bench changes every input one nanosecond after a rising edge. In the exhaustive priority and request sweep, every requester presents a single NONSEQ, so every edge is a legal handover point. The directed scenarios issue only complete, correctly counted bursts and drop the lock only after a full idle cycle.

// File: rtl/prio_rr_arb_pkg.sv
package prio_rr_arb_pkg;

   typedef enum logic [1:0] {
      TR_IDLE = 2'b00,
      TR_BUSY = 2'b01,
      TR_NSEQ = 2'b10,
      TR_SEQ  = 2'b11
   } trans_e;

   localparam logic [2:0] BURST_INCR = 3'b001;
   localparam int         BEAT_W     = 5;

   // number of beats of a fixed-length burst; 1 for single and open INCR
   function automatic logic [BEAT_W-1:0] burst_beats(input logic [2:0] hb);
      logic [BEAT_W-1:0] n;
      case (hb)
         3'b010, 3'b011: n = 5'd4;
         3'b100, 3'b101: n = 5'd8;
         3'b110, 3'b111: n = 5'd16;
         default:        n = 5'd1;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/prio_rr_pick.sv
module prio_rr_pick #(
   parameter int NUM_MST = 4,
   parameter int PRIO_W  = 2,
   parameter int IDX_W   = 2
) (
   input  logic [NUM_MST-1:0]        req_i,
   input  logic [NUM_MST*PRIO_W-1:0] prio_i,
   input  logic [IDX_W-1:0]          ptr_i,
   output logic                      any_o,
   output logic [IDX_W-1:0]          win_o
);

   logic [PRIO_W-1:0]  top_lvl;
   logic [NUM_MST-1:0] elig;

   // highest requested level
   always_comb begin
      top_lvl = '0;
      for (int i = 0; i < NUM_MST; i++) begin
         if (req_i[i] && (prio_i[i*PRIO_W +: PRIO_W] > top_lvl)) begin
            top_lvl = prio_i[i*PRIO_W +: PRIO_W];
         end
      end
   end

   // masters taking part in the rotation
   for (genvar g = 0; g < NUM_MST; g++) begin : g_elig
      assign elig[g] = req_i[g] && (prio_i[g*PRIO_W +: PRIO_W] == top_lvl);
   end

   assign any_o = |req_i;

   // rotating search starting at the pointer
   always_comb begin
      int  j;
      logic found;
      win_o = '0;
      found = 1'b0;
      j     = 0;
      for (int k = 0; k < NUM_MST; k++) begin
         j = int'(ptr_i) + k;
         if (j >= NUM_MST) j = j - NUM_MST;
         if (!found && elig[j]) begin
            win_o = IDX_W'(j);
            found = 1'b1;
         end
      end
   end

   // R1: the winner's level is not below any other requester's level
   always_comb begin
      if (any_o) begin
         for (int i = 0; i < NUM_MST; i++) begin
            if (req_i[i]) begin
               assert_win_top_prio_R1: assert (prio_i[int'(win_o)*PRIO_W +: PRIO_W]
                                               >= prio_i[i*PRIO_W +: PRIO_W]);
            end
         end
      end
   end

endmodule

// File: rtl/prio_rr_burst_watch.sv
module prio_rr_burst_watch
   import prio_rr_arb_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hready_i,
   input  logic       own_req_i,
   input  logic [1:0] own_trans_i,
   input  logic [2:0] own_burst_i,
   input  logic       restart_i,
   output logic       continuing_o
);

   logic [CNT_W-1:0] left_q;
   logic             open_q;
   trans_e           tr;

   assign tr = trans_e'(own_trans_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         open_q <= 1'b0;
      end else if (hready_i) begin
         if (restart_i || !own_req_i || tr == TR_IDLE) begin
            left_q <= '0;
            open_q <= 1'b0;
         end else begin
            case (tr)
               TR_NSEQ: begin
                  left_q <= CNT_W'(burst_beats(own_burst_i) - 1'b1);
                  open_q <= (own_burst_i == BURST_INCR);
               end
               TR_SEQ: begin
                  if (left_q != '0) left_q <= left_q - 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   assign continuing_o = own_req_i && (tr == TR_SEQ || tr == TR_BUSY)
                         && (left_q != '0 || open_q);

   // R7: the remaining-beat count never moves while HREADY is low
   assert_count_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !hready_i |=> $stable(left_q) && $stable(open_q));

endmodule

// File: rtl/prio_rr_slave_arbiter.sv
module prio_rr_slave_arbiter
   import prio_rr_arb_pkg::*;
#(
   parameter int NUM_MST = 4,
   parameter int PRIO_W  = (NUM_MST > 1) ? $clog2(NUM_MST) : 1,
   parameter int IDX_W   = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_MST-1:0]        req_i,
   input  logic [NUM_MST*PRIO_W-1:0] prio_i,
   input  logic [NUM_MST*2-1:0]      htrans_i,
   input  logic [NUM_MST*3-1:0]      hburst_i,
   input  logic [NUM_MST-1:0]        hmastlock_i,
   input  logic                      hready_i,
   output logic [NUM_MST-1:0]        grant_o,
   output logic [IDX_W-1:0]          owner_idx_o,
   output logic                      owner_valid_o
);

   localparam int CNT_W = BEAT_W - 1;

   if (NUM_MST < 2) begin : g_bad_count
      $error("prio_rr_slave_arbiter needs at least two masters");
   end
   if (PRIO_W < $clog2(NUM_MST)) begin : g_bad_prio
      $error("priority field too narrow for the master count");
   end
   if (IDX_W < $clog2(NUM_MST)) begin : g_bad_idx
      $error("index field too narrow for the master count");
   end

   logic [IDX_W-1:0] own_q, ptr_q, win;
   logic             own_v, any_req;
   logic             own_req, own_lock, continuing, may_switch, take, restart;
   logic [1:0]       own_trans;
   logic [2:0]       own_burst;

   prio_rr_pick #(
      .NUM_MST (NUM_MST),
      .PRIO_W  (PRIO_W),
      .IDX_W   (IDX_W)
   ) pick_i (
      .req_i  (req_i),
      .prio_i (prio_i),
      .ptr_i  (ptr_q),
      .any_o  (any_req),
      .win_o  (win)
   );

   assign own_req   = own_v && req_i[own_q];
   assign own_lock  = own_v && hmastlock_i[own_q];
   assign own_trans = htrans_i[int'(own_q)*2 +: 2];
   assign own_burst = hburst_i[int'(own_q)*3 +: 3];

   prio_rr_burst_watch #(
      .CNT_W (CNT_W)
   ) burst_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .hready_i     (hready_i),
      .own_req_i    (own_req),
      .own_trans_i  (own_trans),
      .own_burst_i  (own_burst),
      .restart_i    (restart),
      .continuing_o (continuing)
   );

   assign may_switch = !own_lock && !continuing;
   assign take       = hready_i && may_switch && any_req;
   assign restart    = take && (!own_v || win != own_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q <= '0;
         own_v <= 1'b0;
         ptr_q <= '0;
      end else if (take) begin
         own_q <= win;
         own_v <= 1'b1;
         ptr_q <= (win == IDX_W'(NUM_MST-1)) ? '0 : win + 1'b1;
      end
   end

   for (genvar g = 0; g < NUM_MST; g++) begin : g_grant
      assign grant_o[g] = own_v && (own_q == IDX_W'(g));
   end

   assign owner_idx_o   = own_q;
   assign owner_valid_o = own_v;

   // grant is at most one-hot (R1 names a single winner)
   assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   assert_hold_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !hready_i |=> $stable(grant_o));

   assert_moves_to_requester_R3: assert property (@(posedge clk) disable iff (!rst_n)
      own_v && !any_req |=> $stable(grant_o));

   // covers R7 and R8: an open burst keeps the owner
   assert_burst_keeps_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
      own_v && continuing |=> $stable(own_q) && own_v);

   assert_lock_keeps_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
      own_lock |=> $stable(own_q) && own_v);

   assert_pointer_past_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (ptr_q == ((own_q == IDX_W'(NUM_MST-1)) ? '0 : own_q + 1'b1)));

endmodule

// File: tb/prio_rr_slave_arbiter_tb.sv
`timescale 1ns/1ps
module prio_rr_slave_arbiter_tb_top;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic [7:0]   prio = '0;
   logic [7:0]   htrans = '0;
   logic [11:0]  hburst = '0;
   logic [N-1:0] lock = '0;
   logic         hready = 1'b1;
   logic [N-1:0] grant;
   logic [1:0]   owner_idx;
   logic         owner_valid;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   prio_rr_slave_arbiter #(.NUM_MST(N)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_i         (req),
      .prio_i        (prio),
      .htrans_i      (htrans),
      .hburst_i      (hburst),
      .hmastlock_i   (lock),
      .hready_i      (hready),
      .grant_o       (grant),
      .owner_idx_o   (owner_idx),
      .owner_valid_o (owner_valid)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_owner(input string tag, input int who);
      logic [N-1:0] eg;
      eg = (who < 0) ? '0 : (N'(1) << who);
      checks++;
      if (grant !== eg || owner_valid !== (who >= 0) ||
          (who >= 0 && owner_idx !== 2'(who))) begin
         errors++;
         $display("FAIL %s grant=%b idx=%0d valid=%b expected grant=%b", tag,
                  grant, owner_idx, owner_valid, eg);
      end
   endtask

   task automatic set_m(input int m, input bit r, input logic [1:0] p,
                        input logic [1:0] t, input logic [2:0] b);
      req[m]          = r;
      prio[m*2 +: 2]  = p;
      htrans[m*2 +: 2] = t;
      hburst[m*3 +: 3] = b;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      req = '0; htrans = '0; hburst = '0; lock = '0; prio = '0; hready = 1'b1;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R5 watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int mo, mptr, best, win, ties;
      string tag;

      // ---------- R4 reset state ----------
      do_reset();
      expect_owner("R4 reset no owner", -1);
      for (int m = 0; m < N; m++) set_m(m, 1, 2'd0, 2'b10, 3'b000);
      step();
      expect_owner("R4 first tie goes to master 0", 0);
      step();
      expect_owner("R2 rotation after master 0", 1);

      // ---------- exhaustive sweep: R1 R2 R3 ----------
      do_reset();
      mo = -1; mptr = 0;
      for (int p = 0; p < 256; p++) begin
         for (int r = 0; r < 16; r++) begin
            for (int m = 0; m < N; m++)
               set_m(m, r[m], 2'((p >> (2*m)) & 3), r[m] ? 2'b10 : 2'b00, 3'b000);
            best = -1;
            for (int m = 0; m < N; m++)
               if (r[m] && ((p >> (2*m)) & 3) > best) best = (p >> (2*m)) & 3;
            ties = 0;
            for (int m = 0; m < N; m++)
               if (r[m] && ((p >> (2*m)) & 3) == best) ties++;
            if (r != 0) begin
               win = -1;
               for (int k = 0; k < N; k++) begin
                  int j;
                  j = (mptr + k) % N;
                  if (win < 0 && r[j] && ((p >> (2*j)) & 3) == best) win = j;
               end
               mo = win;
               mptr = (win + 1) % N;
            end
            step();
            tag = (r == 0) ? "R3 parked owner" :
                  (ties > 1) ? "R2 round-robin tie" : "R1 highest level";
            expect_owner(tag, mo);
         end
      end

      // ---------- directed ----------
      do_reset();
      req = '0; htrans = '0;
      hready = 1'b0;
      set_m(2, 1, 2'd1, 2'b10, 3'b000);
      step();
      expect_owner("R5 no grant while hready low", -1);
      hready = 1'b1;
      set_m(2, 0, 2'd0, 2'b00, 3'b000);
      set_m(1, 1, 2'd0, 2'b10, 3'b000);
      step();
      expect_owner("R5 grant after hready edge", 1);
      set_m(1, 0, 2'd0, 2'b00, 3'b000);
      step(); step();
      expect_owner("R3 parked with no request", 1);

      // fixed INCR4 burst by master 1, master 3 waits at higher level
      set_m(1, 1, 2'd0, 2'b10, 3'b011);
      step();
      expect_owner("R7 burst start keeps owner", 1);
      set_m(1, 1, 2'd0, 2'b11, 3'b011);
      set_m(3, 1, 2'd3, 2'b10, 3'b000);
      step();
      expect_owner("R7 beat 2 blocks handover", 1);
      hready = 1'b0;
      step();
      expect_owner("R5 wait state holds owner", 1);
      hready = 1'b1;
      step();
      expect_owner("R7 beat 3 blocks handover", 1);
      step();
      expect_owner("R7 beat 4 blocks handover", 1);
      set_m(1, 1, 2'd0, 2'b00, 3'b000);
      step();
      expect_owner("R6 idle owner hands over", 3);

      // open INCR burst by master 3, master 0 waits at equal level
      set_m(1, 0, 2'd0, 2'b00, 3'b000);
      set_m(3, 1, 2'd3, 2'b10, 3'b001);
      step();
      expect_owner("R8 open burst start", 3);
      set_m(0, 1, 2'd3, 2'b10, 3'b000);
      set_m(3, 1, 2'd3, 2'b11, 3'b001);
      for (int b = 0; b < 4; b++) begin
         step();
         expect_owner("R8 SEQ keeps open burst", 3);
      end
      set_m(3, 1, 2'd3, 2'b01, 3'b001);
      step();
      expect_owner("R8 BUSY keeps open burst", 3);
      set_m(3, 1, 2'd3, 2'b10, 3'b000);
      step();
      expect_owner("R8 NONSEQ ends open burst, R2 tie to 0", 0);

      // lock by master 0
      set_m(3, 0, 2'd0, 2'b00, 3'b000);
      set_m(0, 1, 2'd0, 2'b00, 3'b000);
      lock[0] = 1'b1;
      set_m(2, 1, 2'd3, 2'b10, 3'b000);
      for (int b = 0; b < 3; b++) begin
         step();
         expect_owner("R9 lock keeps owner", 0);
      end
      lock[0] = 1'b0;
      step();
      expect_owner("R9 release lets higher level in", 2);

      // late high-level arrival overtakes an earlier waiter
      set_m(0, 0, 2'd0, 2'b00, 3'b000);
      set_m(2, 1, 2'd0, 2'b10, 3'b011);
      step();
      expect_owner("R10 burst start", 2);
      set_m(2, 1, 2'd0, 2'b11, 3'b011);
      set_m(1, 1, 2'd1, 2'b10, 3'b000);
      step();
      expect_owner("R10 first waiter queued", 2);
      set_m(0, 1, 2'd3, 2'b10, 3'b000);
      step();
      expect_owner("R10 second waiter queued", 2);
      step();
      expect_owner("R10 last beat", 2);
      set_m(2, 0, 2'd0, 2'b00, 3'b000);
      step();
      expect_owner("R10 late high level served first", 0);
      set_m(0, 0, 2'd0, 2'b00, 3'b000);
      step();
      expect_owner("R10 earlier waiter served next", 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule